// File: doc/BRIEF.md
# Asynchronous Static RAM Host Controller

This block lets synchronous logic use an external asynchronous static RAM of 128K bytes, with a 17-bit address and an 8-bit word. A host hands it one word-wide read or write at a time over a valid/ready handshake. The controller latches the request and runs the memory's control strobes (chip select, output enable and write strobe, all active low) through a fixed sequence of phases. It drives the address and the outgoing data, and it controls the shared data bus through a separate drive-enable. Each read ends with the returned byte and a one-cycle response pulse.

Every timing minimum is given in nanoseconds together with the clock period. The controller turns each one into a whole number of clock cycles, rounding up, so the same code meets the memory's rules at any clock rate. A state machine steps through the phases: `ST_IDLE`, `ST_WR_SETUP`, `ST_WR_PULSE`, `ST_WR_HOLD`, `ST_RD_ACCESS` and `ST_RD_RELEASE`. Its transitions are:
- idle to write-setup when a write is accepted;
- idle to read-access when a read is accepted;
- write-setup to write-pulse;
- write-pulse to write-hold;
- write-hold back to idle;
- read-access to read-release, which captures the data;
- read-release back to idle.

Each transition is taken when that phase's cycle count runs out.

Top module: `sram_host_ctrl`

## Requirements
- R1: After reset, chip select, output enable and write strobe are all high, the bus drive-enable is low, the response pulse is low, and the controller accepts requests (ready high).
- R2: A write drives the latched address and data with chip select low. It pulls the write strobe low only while chip select is low and the controller drives the bus. The value then reads back from that address.
- R3: The write strobe stays low for at least the larger of the pulse-width and data-setup cycle counts. Address and outgoing data do not change while it is low.
- R4: Output enable is high in every cycle in which the controller drives the bus.
- R5: A read holds chip select and output enable low with the write strobe high. The byte is captured on the clock edge that ends the access count, which is the larger of the address-access and output-enable-access cycle counts. It reaches the response output that many cycles after acceptance.
- R6: The response valid is raised only for reads and lasts exactly one cycle.
- R7: After output enable rises, the controller waits at least the release cycle count before it drives the bus.
- R8: Ready drops in the cycle after an acceptance and stays low until the access has finished and the minimum cycle time has passed.
- R9: Address, write flag and data are latched at acceptance. Changes on the request inputs during an access do not alter that access.
- R10: A request presented while ready is low is not accepted and leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | DATA_W | Read data |
| sram_ce_n_o | output | 1 | Memory chip select, active low |
| sram_oe_n_o | output | 1 | Memory output enable, active low |
| sram_we_n_o | output | 1 | Memory write strobe, active low |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data toward the memory |
| sram_dq_i | input | DATA_W | Data from the memory |
| sram_dq_oe_o | output | 1 | Drive-enable for the data bus |

## Verification
The bench sweeps every address of a 64-word configuration against a timed memory model, and several corner cases get particular attention.

In the model, read data is valid only once the access time has elapsed and is poisoned before that. A controller that captures one edge early therefore returns the wrong byte, and its read latency is off.

Alternating each write with its read-back forces a bus turnaround every time. A controller that shortens the release phase drives the bus while the memory still holds it.

The model measures write strobes that are too short, or data that changes under the strobe, as they happen.

Changing the request inputs while ready is low shows whether the controller re-latches its inputs mid-access or takes a request it should have ignored.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WR_SETUP   = 3'd1,
        ST_WR_PULSE   = 3'd2,
        ST_WR_HOLD    = 3'd3,
        ST_RD_ACCESS  = 3'd4,
        ST_RD_RELEASE = 3'd5
    } ctrl_state_e;

    // Round a nanosecond figure up to whole clock cycles, at least one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_delay_counter.sv
module sram_delay_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (capture) begin
            write_q <= write_i;
            addr_q  <= addr_i;
            data_q  <= data_i;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= capture;
            if (capture) data_o <= din;
        end
    end
endmodule

// File: rtl/sram_host_ctrl.sv
module sram_host_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_AS_NS       = 0,
    parameter int T_WP_NS       = 7,
    parameter int T_SD_NS       = 5,
    parameter int T_AA_NS       = 10,
    parameter int T_DOE_NS      = 5,
    parameter int T_HZOE_NS     = 5,
    parameter int T_WC_NS       = 10,
    parameter int T_RC_NS       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              sram_ce_n_o,
    output logic              sram_oe_n_o,
    output logic              sram_we_n_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic [DATA_W-1:0] sram_dq_o,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic              sram_dq_oe_o
);

    localparam int AS_CYC  = ns_to_cyc(T_AS_NS, CLK_PERIOD_NS);
    localparam int WP_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_SD_NS, CLK_PERIOD_NS));
    localparam int RD_CYC  = max2(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS));
    localparam int TA_CYC  = ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS);
    localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int RC_CYC  = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC = max2(max2(max2(AS_CYC, WP_CYC), max2(RD_CYC, TA_CYC)),
                                  max2(WC_CYC, RC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int RUN_W   = CNT_W + 1;

    ctrl_state_e state_q, state_d;

    logic              accept;
    logic              phase_done;
    logic              phase_load;
    logic [CNT_W-1:0]  phase_len_m1;
    logic              cyc_zero;
    logic [CNT_W-1:0]  cyc_len_m1;
    logic              rd_capture;
    logic              lat_write;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;

    assign req_ready_o = (state_q == ST_IDLE) && cyc_zero;
    assign accept      = req_ready_o && req_valid_i;
    assign rd_capture  = (state_q == ST_RD_ACCESS) && phase_done;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept)     state_d = req_write_i ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_WR_SETUP:   if (phase_done) state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (phase_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:    if (phase_done) state_d = ST_IDLE;
            ST_RD_ACCESS:  if (phase_done) state_d = ST_RD_RELEASE;
            ST_RD_RELEASE: if (phase_done) state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Length of the phase being entered
    always_comb begin
        unique case (state_d)
            ST_WR_SETUP:   phase_len_m1 = CNT_W'(AS_CYC - 1);
            ST_WR_PULSE:   phase_len_m1 = CNT_W'(WP_CYC - 1);
            ST_RD_ACCESS:  phase_len_m1 = CNT_W'(RD_CYC - 1);
            ST_RD_RELEASE: phase_len_m1 = CNT_W'(TA_CYC - 1);
            default:       phase_len_m1 = '0;
        endcase
    end
    assign phase_load = (state_d != state_q);
    assign cyc_len_m1 = req_write_i ? CNT_W'(WC_CYC - 1) : CNT_W'(RC_CYC - 1);

    sram_delay_counter #(.W(CNT_W)) i_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_len_m1),
        .zero     (phase_done)
    );

    sram_delay_counter #(.W(CNT_W)) i_cycle_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cyc_len_m1),
        .zero     (cyc_zero)
    );

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_req_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .write_i (req_write_i),
        .addr_i  (req_addr_i),
        .data_i  (req_wdata_i),
        .write_q (lat_write),
        .addr_q  (lat_addr),
        .data_q  (lat_data)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) i_rd_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .din     (sram_dq_i),
        .valid_o (rsp_valid_o),
        .data_o  (rsp_rdata_o)
    );

    // Pin decode from state
    always_comb begin
        sram_ce_n_o  = 1'b1;
        sram_oe_n_o  = 1'b1;
        sram_we_n_o  = 1'b1;
        sram_dq_oe_o = 1'b0;
        unique case (state_q)
            ST_WR_SETUP: begin
                sram_ce_n_o  = 1'b0;
                sram_dq_oe_o = 1'b1;
            end
            ST_WR_PULSE: begin
                sram_ce_n_o  = 1'b0;
                sram_we_n_o  = 1'b0;
                sram_dq_oe_o = 1'b1;
            end
            ST_WR_HOLD: begin
                sram_ce_n_o  = 1'b0;
                sram_dq_oe_o = 1'b1;
            end
            ST_RD_ACCESS: begin
                sram_ce_n_o = 1'b0;
                sram_oe_n_o = 1'b0;
            end
            default: begin
                sram_ce_n_o  = 1'b1;
            end
        endcase
    end
    assign sram_addr_o = lat_addr;
    assign sram_dq_o   = lat_data;

    // Run-length trackers for the timing checks
    logic [RUN_W-1:0] we_low_run, oe_high_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_run  <= '0;
            oe_high_run <= '1;
        end else begin
            we_low_run  <= !sram_we_n_o ? ((we_low_run == '1) ? we_low_run : we_low_run + 1'b1) : '0;
            oe_high_run <= sram_oe_n_o ? ((oe_high_run == '1) ? oe_high_run : oe_high_run + 1'b1) : '0;
        end
    end

    // R3
    wp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n_o) |-> (we_low_run >= RUN_W'(WP_CYC)));

    // R3
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n_o && $past(!sram_we_n_o)) |-> ($stable(sram_dq_o) && $stable(sram_addr_o)));

    // R2
    we_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n_o |-> (!sram_ce_n_o && sram_dq_oe_o && lat_write));

    // R4
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe_o |-> sram_oe_n_o);

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe_o) |-> (oe_high_run >= RUN_W'(TA_CYC)));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready_o);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n_o && $past(!sram_ce_n_o)) |-> $stable(sram_addr_o));

endmodule

// File: tb/test_sram_host_ctrl.sv
module test_sram_host_ctrl;

    localparam int AW       = 6;
    localparam int DW       = 8;
    localparam int CLK_NS   = 5;
    localparam int AS_NS    = 0;
    localparam int WP_NS    = 7;
    localparam int SD_NS    = 5;
    localparam int AA_NS    = 10;
    localparam int DOE_NS   = 5;
    localparam int HZ_NS    = 5;
    localparam int WC_NS    = 10;
    localparam int RC_NS    = 10;
    localparam int NWORDS   = 1 << AW;
    localparam int RD_NS    = (AA_NS > DOE_NS) ? AA_NS : DOE_NS;
    localparam int NEED_RD  = (RD_NS + CLK_NS - 1) / CLK_NS;
    localparam int PULSE_NS = (WP_NS > SD_NS) ? WP_NS : SD_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          ce_n, oe_n, we_n, dq_oe;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] dq_out, dq_in;

    int n_checks = 0;
    int n_fail   = 0;
    int mon_r3 = 0, mon_r4 = 0, mon_r7 = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sram_host_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_NS),
        .T_AS_NS(AS_NS), .T_WP_NS(WP_NS), .T_SD_NS(SD_NS),
        .T_AA_NS(AA_NS), .T_DOE_NS(DOE_NS), .T_HZOE_NS(HZ_NS),
        .T_WC_NS(WC_NS), .T_RC_NS(RC_NS)
    ) i_sram_host_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n), .sram_we_n_o(we_n),
        .sram_addr_o(m_addr), .sram_dq_o(dq_out), .sram_dq_i(dq_in),
        .sram_dq_oe_o(dq_oe)
    );

    // Timed memory model
    logic [DW-1:0] mem [NWORDS];
    int  rd_run = 0, we_run = 0, oe_hi_run = 100;
    logic [DW-1:0] we_snap = '0;
    logic [AW-1:0] a_snap  = '0;
    logic rd_cond;
    assign rd_cond = !ce_n && !oe_n && we_n;
    assign dq_in = (rd_cond && (rd_run + 1 >= NEED_RD)) ? mem[m_addr] : 8'hEE;

    initial for (int i = 0; i < NWORDS; i++) mem[i] = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            rd_run <= rd_cond ? rd_run + 1 : 0;
            oe_hi_run <= oe_n ? ((oe_hi_run < 100) ? oe_hi_run + 1 : oe_hi_run) : 0;
            if (dq_oe && !oe_n) mon_r4 <= mon_r4 + 1;
            if (dq_oe && (oe_hi_run * CLK_NS < HZ_NS)) mon_r7 <= mon_r7 + 1;
            if (!we_n) begin
                we_run <= we_run + 1;
                if (we_run == 0) begin
                    we_snap <= dq_out;
                    a_snap  <= m_addr;
                end else if (dq_out != we_snap || m_addr != a_snap) begin
                    mon_r3 <= mon_r3 + 1;
                end
            end else begin
                we_run <= 0;
                if (we_run != 0) begin
                    if (we_run * CLK_NS < PULSE_NS) mon_r3 <= mon_r3 + 1;
                    if (!ce_n && dq_oe) mem[m_addr] <= dq_out;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'((a * 29 + 7) & 8'hFF);
    endfunction

    task automatic issue(input bit wr, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        issue(1'b1, a, d);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] exp);
        int k;
        issue(1'b0, a, 8'h00);
        k = 1;
        while (!rsp_valid && k < 20) begin
            @(negedge clk);
            k++;
        end
        // R5 data and latency
        check(rsp_rdata == exp, "R5 data", int'(rsp_rdata), int'(exp));
        check(k - 1 == NEED_RD, "R5 latency", k - 1, NEED_RD);
        @(negedge clk);
        // R6 single-cycle pulse
        check(!rsp_valid, "R6 pulse", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ce_n == 1'b1, "R1 ce", int'(ce_n), 1);
        check(oe_n == 1'b1, "R1 oe", int'(oe_n), 1);
        check(we_n == 1'b1, "R1 we", int'(we_n), 1);
        check(dq_oe == 1'b0, "R1 dq_oe", int'(dq_oe), 0);
        check(rsp_valid == 1'b0, "R1 rsp", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);

        // R2 / R5: fill every word, then read all back
        for (int a = 0; a < NWORDS; a++) do_write(a, pat1(a));
        for (int a = 0; a < NWORDS; a++) do_read(a, pat1(a));

        // R7: alternate write and read-back so every write follows a read
        for (int a = 0; a < NWORDS; a++) begin
            do_write(a, pat1(a) ^ 8'hA5);
            do_read(a, pat1(a) ^ 8'hA5);
        end

        // R8 / R9 / R10: busy window with changing request inputs
        do_write(5, 8'h3C);
        check(req_ready == 1'b0, "R8 busy", int'(req_ready), 0);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = AW'(9);
        req_wdata = 8'hC3;
        @(negedge clk);
        check(req_ready == 1'b0, "R8 busy2", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        do_read(5, 8'h3C);                    // R9 latched write kept
        do_read(9, pat1(9) ^ 8'hA5);          // R10 ignored request
        do_read(NWORDS - 1, pat1(NWORDS - 1) ^ 8'hA5);

        check(mon_r3 == 0, "R3 strobe", mon_r3, 0);
        check(mon_r4 == 0, "R4 contention", mon_r4, 0);
        check(mon_r7 == 0, "R7 turnaround", mon_r7, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule